// File: doc/BRIEF.md
# Reservation Monitor for Load-Reserve / Store-Conditional

This block holds the single hidden reservation that lets a processor build atomic read-modify-write sequences. A load-and-reserve request arms the reservation and records which aligned address granule it covers. A later store-conditional is allowed to write memory only while that reservation is still armed and covers the store's granule. The reservation is dropped after every store-conditional, whether the store was allowed or not. Software never reads the reservation directly. It learns the outcome from the equal flag of condition field 0, which this block drives high on success.

Writes made by other agents arrive on a snoop input. A snooped write that lands in the reserved granule cancels the reservation, so a later store-conditional fails and software retries its sequence. Requests come in word (4-byte) and doubleword (8-byte) forms. A store-conditional whose address is not aligned to its access size is refused.

The outcome of a request is registered. It appears on the outputs one clock after the request is presented.

Top module: `rsv_monitor`

## Requirements
- R1: Synchronous active-high reset clears the reservation and drives `sc_done`, `cr0_eq` and `store_en` low. A store-conditional issued right after reset fails.
- R2: `req_op` = 2'b01 (load-and-reserve) arms the reservation and records `req_addr >> GRAN_LG` as its granule. A later store-conditional to any byte of that granule succeeds. One cycle after the store-conditional request, `sc_done`, `cr0_eq` and `store_en` are all 1.
- R3: A store-conditional (`req_op` = 2'b10) with no armed reservation gives `sc_done` = 1, `cr0_eq` = 0 and `store_en` = 0 one cycle later.
- R4: Every store-conditional disarms the reservation, whether it succeeds or fails. A second store-conditional with no load-and-reserve in between fails.
- R5: A store-conditional to a granule other than the recorded one fails.
- R6: A snooped write (`snoop_valid` = 1) whose `snoop_addr` lies in the reserved granule disarms the reservation. A snooped write to another granule leaves it armed.
- R7: When a snooped write hits the reserved granule in the same cycle as a store-conditional to it, the snoop is taken first and the store-conditional fails.
- R8: When a load-and-reserve and a snooped write to the same granule arrive in the same cycle, the load-and-reserve wins and the reservation is armed afterwards.
- R9: A new load-and-reserve replaces any earlier reservation. Only the most recently reserved granule can succeed.
- R10: `req_dword` = 0 selects a 4-byte access and 1 an 8-byte access. A store-conditional succeeds only if `req_addr` is a multiple of its access size; otherwise it fails and still disarms the reservation.
- R11: `req_op` = 2'b00 (idle) and 2'b11 (reserved code) produce no output and leave the reservation unchanged.
- R12: `sc_done` pulses for exactly one cycle per store-conditional and at no other time. `store_en` is high only together with `sc_done` and `cr0_eq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_op | input | 2 | Request code: 00 idle, 01 load-and-reserve, 10 store-conditional, 11 reserved |
| req_dword | input | 1 | Access size: 0 word, 1 doubleword |
| req_addr | input | AW | Byte address of the request |
| snoop_valid | input | 1 | A write by another agent is presented this cycle |
| snoop_addr | input | AW | Byte address of the snooped write |
| store_en | output | 1 | Memory write enable for a successful store-conditional |
| sc_done | output | 1 | A store-conditional outcome is presented this cycle |
| cr0_eq | output | 1 | Equal flag for condition field 0: 1 on success |

## Verification
The test sequences pair a load-and-reserve with store-conditionals to the same byte, another byte in the same granule, and a neighbouring granule. These separate correct granule rounding from exact-address matching. Back-to-back store-conditionals, and a retry after a failed one, show that the reservation is dropped on every outcome and not only on success. Snoops are placed before, together with, and beside the reserved granule, alone and in the same cycle as a load-and-reserve or a store-conditional. This fixes both the priority rules and the hit/miss comparison. Word and doubleword forms with aligned and misaligned offsets, plus the reserved request code between a reserve and its store, show that size checking and idle decoding do not disturb the reservation.

// File: rtl/rsv_pkg.sv
package rsv_pkg;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'b00,
        OP_LRSV  = 2'b01,
        OP_SCOND = 2'b10,
        OP_RSVD  = 2'b11
    } rsv_op_e;

    typedef struct packed {
        logic is_lr;
        logic is_sc;
        logic size_ok;
    } req_dec_t;

    typedef struct packed {
        logic done;
        logic eq;
        logic wr;
    } sc_result_t;

    localparam sc_result_t RESULT_NONE = '{done: 1'b0, eq: 1'b0, wr: 1'b0};

    function automatic rsv_op_e op_of(input logic [1:0] code);
        return rsv_op_e'(code);
    endfunction

    function automatic sc_result_t make_result(input logic ok);
        sc_result_t r;
        r.done = 1'b1;
        r.eq   = ok;
        r.wr   = ok;
        return r;
    endfunction

endpackage

// File: rtl/rsv_decode.sv
module rsv_decode
    import rsv_pkg::*;
#(
    parameter int AW      = 32,
    parameter int GRAN_LG = 4,
    localparam int GW     = AW - GRAN_LG
) (
    input  logic [1:0]    req_op,
    input  logic          req_dword,
    input  logic [AW-1:0] req_addr,
    output req_dec_t      dec,
    output logic [GW-1:0] req_gran
);
    localparam logic [AW-1:0] MASK_W = AW'(3);
    localparam logic [AW-1:0] MASK_D = AW'(7);

    rsv_op_e op;
    logic [AW-1:0] low_mask;

    always_comb begin
        op          = op_of(req_op);
        low_mask    = req_dword ? MASK_D : MASK_W;
        dec.is_lr   = (op == OP_LRSV);
        dec.is_sc   = (op == OP_SCOND);
        dec.size_ok = ((req_addr & low_mask) == '0);
        req_gran    = GW'(req_addr >> GRAN_LG);
    end

endmodule

// File: rtl/rsv_track.sv
module rsv_track #(
    parameter int AW      = 32,
    parameter int GRAN_LG = 4,
    localparam int GW     = AW - GRAN_LG
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          arm,
    input  logic [GW-1:0] arm_gran,
    input  logic          consume,
    input  logic          snoop_valid,
    input  logic [AW-1:0] snoop_addr,
    output logic          held,
    output logic [GW-1:0] held_gran,
    output logic          snoop_hit
);
    logic [GW-1:0] snoop_gran;

    always_comb begin
        snoop_gran = GW'(snoop_addr >> GRAN_LG);
        snoop_hit  = snoop_valid && held && (snoop_gran == held_gran);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            held      <= 1'b0;
            held_gran <= '0;
        end else if (arm) begin
            held      <= 1'b1;
            held_gran <= arm_gran;
        end else if (consume || snoop_hit) begin
            held      <= 1'b0;
        end
    end

endmodule

// File: rtl/rsv_resolve.sv
module rsv_resolve
    import rsv_pkg::*;
#(
    parameter int AW      = 32,
    parameter int GRAN_LG = 4,
    localparam int GW     = AW - GRAN_LG
) (
    input  logic          clk,
    input  logic          rst,
    input  req_dec_t      dec,
    input  logic [GW-1:0] req_gran,
    input  logic          held,
    input  logic [GW-1:0] held_gran,
    input  logic          snoop_hit,
    output sc_result_t    result
);
    logic ok;

    always_comb begin
        ok = held && !snoop_hit && dec.size_ok && (req_gran == held_gran);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            result <= RESULT_NONE;
        end else if (dec.is_sc) begin
            result <= make_result(ok);
        end else begin
            result <= RESULT_NONE;
        end
    end

endmodule

// File: rtl/rsv_monitor.sv
module rsv_monitor
    import rsv_pkg::*;
#(
    parameter int AW      = 32,
    parameter int GRAN_LG = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [1:0]    req_op,
    input  logic          req_dword,
    input  logic [AW-1:0] req_addr,
    input  logic          snoop_valid,
    input  logic [AW-1:0] snoop_addr,
    output logic          store_en,
    output logic          sc_done,
    output logic          cr0_eq
);
    localparam int GW = AW - GRAN_LG;

    req_dec_t      dec;
    logic [GW-1:0] req_gran;
    logic          rsv_held;
    logic [GW-1:0] rsv_gran;
    logic          snoop_hit;
    sc_result_t    result;

    rsv_decode #(.AW(AW), .GRAN_LG(GRAN_LG)) decode_i (
        .req_op    (req_op),
        .req_dword (req_dword),
        .req_addr  (req_addr),
        .dec       (dec),
        .req_gran  (req_gran)
    );

    rsv_track #(.AW(AW), .GRAN_LG(GRAN_LG)) track_i (
        .clk         (clk),
        .rst         (rst),
        .arm         (dec.is_lr),
        .arm_gran    (req_gran),
        .consume     (dec.is_sc),
        .snoop_valid (snoop_valid),
        .snoop_addr  (snoop_addr),
        .held        (rsv_held),
        .held_gran   (rsv_gran),
        .snoop_hit   (snoop_hit)
    );

    rsv_resolve #(.AW(AW), .GRAN_LG(GRAN_LG)) resolve_i (
        .clk       (clk),
        .rst       (rst),
        .dec       (dec),
        .req_gran  (req_gran),
        .held      (rsv_held),
        .held_gran (rsv_gran),
        .snoop_hit (snoop_hit),
        .result    (result)
    );

    always_comb begin
        store_en = result.wr;
        sc_done  = result.done;
        cr0_eq   = result.eq;
    end

endmodule

// File: rtl/rsv_monitor_chk.sv
module rsv_monitor_chk (
    input logic       clk,
    input logic       rst,
    input logic [1:0] req_op,
    input logic       snoop_valid,
    input logic       rsv_held,
    input logic       store_en,
    input logic       sc_done,
    input logic       cr0_eq
);

    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!sc_done && !store_en && !rsv_held));

    assert_reserve_arms_R2: assert property (@(posedge clk) disable iff (rst)
        (req_op == 2'b01) |=> rsv_held);

    assert_unreserved_no_store_R3: assert property (@(posedge clk) disable iff (rst)
        (req_op == 2'b10 && !rsv_held) |=> (sc_done && !cr0_eq && !store_en));

    assert_cond_disarms_R4: assert property (@(posedge clk) disable iff (rst)
        (req_op == 2'b10) |=> !rsv_held);

    assert_idle_keeps_R11: assert property (@(posedge clk) disable iff (rst)
        ((req_op == 2'b00 || req_op == 2'b11) && !snoop_valid) |=> (rsv_held == $past(rsv_held) && !sc_done));

    assert_store_gated_R12: assert property (@(posedge clk) disable iff (rst)
        store_en |-> (sc_done && cr0_eq));

    assert_done_source_R12: assert property (@(posedge clk) disable iff (rst)
        sc_done |-> ($past(req_op) == 2'b10));

endmodule

bind rsv_monitor rsv_monitor_chk chk_i (
    .clk         (clk),
    .rst         (rst),
    .req_op      (req_op),
    .snoop_valid (snoop_valid),
    .rsv_held    (rsv_held),
    .store_en    (store_en),
    .sc_done     (sc_done),
    .cr0_eq      (cr0_eq)
);

// File: tb/rsv_monitor_tb_top.sv
`timescale 1ns/1ps
module rsv_monitor_tb_top;

    localparam int AW      = 32;
    localparam int GRAN_LG = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [1:0]    req_op = 2'b00;
    logic          req_dword = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic          snoop_valid = 1'b0;
    logic [AW-1:0] snoop_addr = '0;
    logic          store_en, sc_done, cr0_eq;

    always #10 clk = ~clk;

    rsv_monitor #(.AW(AW), .GRAN_LG(GRAN_LG)) dut_i (
        .clk(clk), .rst(rst), .req_op(req_op), .req_dword(req_dword),
        .req_addr(req_addr), .snoop_valid(snoop_valid), .snoop_addr(snoop_addr),
        .store_en(store_en), .sc_done(sc_done), .cr0_eq(cr0_eq)
    );

    typedef struct {
        bit    ok;
        string tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_chk  = 0;
    int   n_fail = 0;
    bit   mon_on = 1'b0;

    bit            m_held = 1'b0;
    logic [AW-1:0] m_gran = '0;

    function automatic logic [AW-1:0] gran(input logic [AW-1:0] a);
        return a >> GRAN_LG;
    endfunction

    task automatic check(input bit cond, input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (!cond) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // One request per cycle; the reference model is updated as it is driven.
    task automatic drive(input logic [1:0] op, input bit dw, input logic [AW-1:0] a,
                         input bit sv, input logic [AW-1:0] sa, input string tag);
        bit hit, ok;
        exp_t e;
        @(negedge clk);
        req_op = op; req_dword = dw; req_addr = a;
        snoop_valid = sv; snoop_addr = sa;
        hit = sv && m_held && (gran(sa) == m_gran);
        if (op == 2'b10) begin
            ok = m_held && !hit && (gran(a) == m_gran) &&
                 ((a & (dw ? 32'd7 : 32'd3)) == 0);
            e.ok = ok; e.tag = tag;
            exp_q.push_back(e);
            m_held = 1'b0;
        end else if (op == 2'b01) begin
            m_held = 1'b1;
            m_gran = gran(a);
        end else if (hit) begin
            m_held = 1'b0;
        end
    endtask

    task automatic lr(input logic [AW-1:0] a, input bit dw, input string tag);
        drive(2'b01, dw, a, 1'b0, '0, tag);
    endtask

    task automatic sc(input logic [AW-1:0] a, input bit dw, input string tag);
        drive(2'b10, dw, a, 1'b0, '0, tag);
    endtask

    task automatic idle(input string tag);
        drive(2'b00, 1'b0, '0, 1'b0, '0, tag);
    endtask

    // Monitor: compares every cycle's outputs with the queue.
    always @(negedge clk) begin
        if (mon_on) begin
            if (sc_done) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R12", "unexpected sc_done", 1, 0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(cr0_eq == e.ok, e.tag, "cr0_eq", int'(cr0_eq), int'(e.ok));
                    check(store_en == e.ok, e.tag, "store_en", int'(store_en), int'(e.ok));
                end
            end else if (store_en || cr0_eq) begin
                check(1'b0, "R12", "output without sc_done", int'({store_en, cr0_eq}), 0);
            end
        end
    end

    bit finished = 1'b0;

    initial begin
        #(20 * 5000);
        if (!finished) begin
            check(1'b0, "R12", "watchdog expired", 0, 1);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(!sc_done && !store_en && !cr0_eq, "R1", "outputs in reset",
              int'({sc_done, store_en, cr0_eq}), 0);
        rst = 1'b0;
        @(negedge clk);
        check(!sc_done && !store_en && !cr0_eq, "R1", "outputs after reset",
              int'({sc_done, store_en, cr0_eq}), 0);
        mon_on = 1'b1;

        sc(32'h100, 1'b0, "R1");
        lr(32'h100, 1'b0, "R2");
        sc(32'h104, 1'b0, "R2");
        sc(32'h100, 1'b0, "R4");
        sc(32'h200, 1'b0, "R3");
        lr(32'h200, 1'b0, "R5");
        sc(32'h210, 1'b0, "R5");
        sc(32'h200, 1'b0, "R4");
        lr(32'h300, 1'b0, "R6");
        drive(2'b00, 1'b0, '0, 1'b1, 32'h308, "R6");
        sc(32'h300, 1'b0, "R6");
        lr(32'h300, 1'b0, "R6");
        drive(2'b00, 1'b0, '0, 1'b1, 32'h310, "R6");
        sc(32'h30C, 1'b0, "R6");
        lr(32'h400, 1'b0, "R7");
        drive(2'b10, 1'b0, 32'h400, 1'b1, 32'h40C, "R7");
        drive(2'b01, 1'b0, 32'h500, 1'b1, 32'h500, "R8");
        sc(32'h500, 1'b0, "R8");
        lr(32'h600, 1'b0, "R9");
        lr(32'h700, 1'b0, "R9");
        sc(32'h600, 1'b0, "R9");
        lr(32'h600, 1'b0, "R9");
        lr(32'h700, 1'b0, "R9");
        sc(32'h708, 1'b0, "R9");
        lr(32'h800, 1'b1, "R10");
        sc(32'h804, 1'b1, "R10");
        sc(32'h800, 1'b1, "R10");
        lr(32'h800, 1'b1, "R10");
        sc(32'h804, 1'b0, "R10");
        lr(32'h800, 1'b1, "R10");
        sc(32'h808, 1'b1, "R10");
        lr(32'h800, 1'b0, "R10");
        sc(32'h802, 1'b0, "R10");
        lr(32'h900, 1'b0, "R11");
        drive(2'b11, 1'b1, 32'h900, 1'b0, '0, "R11");
        idle("R11");
        drive(2'b11, 1'b0, 32'hA00, 1'b0, '0, "R11");
        sc(32'h900, 1'b0, "R11");
        drive(2'b11, 1'b0, 32'h900, 1'b0, '0, "R11");
        sc(32'h900, 1'b0, "R11");
        lr(32'hB00, 1'b0, "R12");
        sc(32'hB00, 1'b0, "R12");
        sc(32'hB00, 1'b0, "R12");
        lr(32'hB00, 1'b0, "R12");
        sc(32'hB04, 1'b0, "R12");
        repeat (3) idle("R12");
        check(exp_q.size() == 0, "R12", "outcomes left unreported", exp_q.size(), 0);

        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule